// File: doc/BRIEF.md
# Operand Hazard and Forwarding Unit

This block sits beside the decode stage of a five-stage integer pipeline with 32 architectural registers, where branches and jump-register instructions compare their operands in decode. Each cycle it compares the two source register indices of the decoding instruction against the destinations of the instructions now in execute and memory. From that it decides whether decode must hold, and which value each operand should use: the register-file read, the execute-stage ALU result, or the memory-stage write-back value.

The unit is purely combinational. It has two policies, chosen by a mode input. With forwarding off, every dependency stalls. With forwarding on, results are bypassed wherever the data already exists. Operands used by a branch or jump-register comparison follow stricter rules than operands used by the ALU, because they are consumed a full stage earlier. No check is made against writeback: the register file is expected to pass a same-cycle write through to its decode read. A link destination (register 31, carrying the instruction address plus 8) is an ordinary result here.

Top module: `fwd_hazard_unit`

## Requirements
- R1: A producer stage (execute or memory) creates a dependency for an operand only when its write-enable is high, its destination index equals that operand's index, and the decode instruction flags that operand as needed (ALU need or branch need). An unflagged operand is never stalled on or forwarded.
- R2: A producer whose destination index is 0 never creates a dependency, whatever its write-enable.
- R3: With forwarding on, an ALU-needed operand matching the memory-stage destination takes the memory-stage value, with tag 2'b01 (from writeback).
- R4: With forwarding on, an ALU-needed operand matching a non-load execute-stage destination takes the execute-stage ALU result, with tag 2'b10 (from memory). This wins over a simultaneous memory-stage match.
- R5: With forwarding on, an ALU-needed operand matching an execute-stage load raises stall and takes no execute-stage value. A memory-stage match on the same operand still forwards as in R3.
- R6: With forwarding off, any ALU-operand dependency on execute or memory raises stall. All tags stay 2'b00, the memory-forward flags stay low and the values pass through.
- R7: A branch-needed operand matching the execute-stage destination raises both stall and branch_stall, in either mode.
- R8: Without an R7 condition, a branch-needed operand matching the memory-stage destination raises stall when forwarding is off or the memory-stage instruction is a load. branch_stall stays low in this case.
- R9: With forwarding on, a branch-needed operand matching a non-load memory-stage destination takes the memory-stage value and raises its own memory-to-decode flag, provided no R7 condition exists on either operand. It does not stall.
- R10: Destination index 31 is matched and forwarded like any other nonzero index.
- R11: With no dependency, each operand value equals its register-file input, the tags are 2'b00, both flags are low and stall and branch_stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | 1 = stall-plus-forward policy, 0 = stall-only policy |
| dec_rs_idx | input | 5 | First source register index in decode |
| dec_rt_idx | input | 5 | Second source register index in decode |
| dec_rs_alu | input | 1 | First source is used by the ALU |
| dec_rt_alu | input | 1 | Second source is used by the ALU |
| dec_rs_br | input | 1 | First source is used by a decode-stage comparison |
| dec_rt_br | input | 1 | Second source is used by a decode-stage comparison |
| rf_rs_val | input | 32 | Register-file value for the first source |
| rf_rt_val | input | 32 | Register-file value for the second source |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination index |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_result | input | 32 | Execute-stage ALU result |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination index |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 32 | Memory-stage write-back value |
| rs_val | output | 32 | Resolved first operand |
| rt_val | output | 32 | Resolved second operand |
| rs_src | output | 2 | First operand source tag: 0 none, 1 from writeback, 2 from memory |
| rt_src | output | 2 | Second operand source tag, same encoding |
| rs_m2d | output | 1 | First operand forwarded memory-to-decode for a comparison |
| rt_m2d | output | 1 | Second operand forwarded memory-to-decode for a comparison |
| stall | output | 1 | Decode must hold this cycle |
| branch_stall | output | 1 | Stall caused by a comparison operand waiting on execute |

## Verification
Because the unit holds no state, a wrong decision shows at the ports in the same cycle as the input pattern that triggers it. A mis-ordered priority shows up as an operand carrying the memory-stage value under tag 2'b01 where the execute result was due. A lost register-0 exclusion appears as a spurious stall on a nop. A branch rule that ignores loads shows up as a forwarded value with the stall low. The bench drives clustered register indices so that both producers often match both operands at once. It compares every output against a model after every pattern.

// File: rtl/fhu_pkg.sv
package fhu_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_WBACK   = 2'd1,
    SRC_EXRES   = 2'd2
  } src_tag_t;
endpackage

// File: rtl/fhu_match.sv
module fhu_match #(
  parameter int RIDX_W = 5
) (
  input  logic              wen,
  input  logic [RIDX_W-1:0] dst,
  input  logic [RIDX_W-1:0] idx,
  input  logic              need,
  output logic              hit
);
  always_comb begin
    hit = need && wen && (dst != '0) && (dst == idx);
  end
endmodule

// File: rtl/fhu_operand.sv
module fhu_operand
  import fhu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              fwd_en,
  input  logic [RIDX_W-1:0] idx,
  input  logic              need_alu,
  input  logic              need_br,
  input  logic [XLEN-1:0]   rf_val,
  input  logic              ex_wen,
  input  logic [RIDX_W-1:0] ex_dst,
  input  logic              ex_load,
  input  logic [XLEN-1:0]   ex_result,
  input  logic              mem_wen,
  input  logic [RIDX_W-1:0] mem_dst,
  input  logic              mem_load,
  input  logic [XLEN-1:0]   mem_result,
  input  logic              br_ex_block,
  output logic [XLEN-1:0]   val,
  output logic [1:0]        tag,
  output logic              m2d,
  output logic              alu_stall,
  output logic              br_ex_haz,
  output logic              br_mem_stall
);
  logic alu_ex, alu_mem, br_ex, br_mem;

  fhu_match #(.RIDX_W(RIDX_W)) u_alu_ex (
    .wen(ex_wen), .dst(ex_dst), .idx(idx), .need(need_alu), .hit(alu_ex));
  fhu_match #(.RIDX_W(RIDX_W)) u_alu_mem (
    .wen(mem_wen), .dst(mem_dst), .idx(idx), .need(need_alu), .hit(alu_mem));
  fhu_match #(.RIDX_W(RIDX_W)) u_br_ex (
    .wen(ex_wen), .dst(ex_dst), .idx(idx), .need(need_br), .hit(br_ex));
  fhu_match #(.RIDX_W(RIDX_W)) u_br_mem (
    .wen(mem_wen), .dst(mem_dst), .idx(idx), .need(need_br), .hit(br_mem));

  always_comb begin
    alu_stall    = (alu_ex && (!fwd_en || ex_load)) || (alu_mem && !fwd_en);
    br_ex_haz    = br_ex;
    br_mem_stall = br_mem && (!fwd_en || mem_load);
    m2d          = br_mem && fwd_en && !mem_load && !br_ex_block;
  end

  always_comb begin
    val = rf_val;
    tag = SRC_REGFILE;
    if (fwd_en && alu_ex && !ex_load) begin
      val = ex_result;
      tag = SRC_EXRES;
    end else if (fwd_en && alu_mem) begin
      val = mem_result;
      tag = SRC_WBACK;
    end
    if (m2d && tag != SRC_EXRES) begin
      val = mem_result;
    end
  end

  always_comb begin
    AST_M2D_NONLOAD: assert (!m2d || (fwd_en && !mem_load && !br_ex_block)); // R9
    AST_STALLONLY_NOTAG: assert (fwd_en || (tag == SRC_REGFILE && !m2d)); // R6
    AST_UNNEEDED_QUIET: assert ((need_alu || need_br) || (val == rf_val && tag == SRC_REGFILE && !alu_stall && !br_mem_stall)); // R1
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fhu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NREGS  = 32,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int NOPS   = 2
) (
  input  logic              fwd_en,
  input  logic [RIDX_W-1:0] dec_rs_idx,
  input  logic [RIDX_W-1:0] dec_rt_idx,
  input  logic              dec_rs_alu,
  input  logic              dec_rt_alu,
  input  logic              dec_rs_br,
  input  logic              dec_rt_br,
  input  logic [XLEN-1:0]   rf_rs_val,
  input  logic [XLEN-1:0]   rf_rt_val,
  input  logic              ex_wen,
  input  logic [RIDX_W-1:0] ex_dst,
  input  logic              ex_load,
  input  logic [XLEN-1:0]   ex_result,
  input  logic              mem_wen,
  input  logic [RIDX_W-1:0] mem_dst,
  input  logic              mem_load,
  input  logic [XLEN-1:0]   mem_result,
  output logic [XLEN-1:0]   rs_val,
  output logic [XLEN-1:0]   rt_val,
  output logic [1:0]        rs_src,
  output logic [1:0]        rt_src,
  output logic              rs_m2d,
  output logic              rt_m2d,
  output logic              stall,
  output logic              branch_stall
);
  logic [RIDX_W-1:0] op_idx    [NOPS];
  logic              op_alu    [NOPS];
  logic              op_br     [NOPS];
  logic [XLEN-1:0]   op_rf     [NOPS];
  logic [XLEN-1:0]   op_val    [NOPS];
  logic [1:0]        op_tag    [NOPS];
  logic              op_m2d    [NOPS];
  logic [NOPS-1:0]   op_astall;
  logic [NOPS-1:0]   op_brex;
  logic [NOPS-1:0]   op_brmem;
  logic              any_br_ex;

  always_comb begin
    op_idx[0] = dec_rs_idx;  op_idx[1] = dec_rt_idx;
    op_alu[0] = dec_rs_alu;  op_alu[1] = dec_rt_alu;
    op_br[0]  = dec_rs_br;   op_br[1]  = dec_rt_br;
    op_rf[0]  = rf_rs_val;   op_rf[1]  = rf_rt_val;
  end

  assign any_br_ex = |op_brex;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fhu_operand #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_op (
      .fwd_en      (fwd_en),
      .idx         (op_idx[g]),
      .need_alu    (op_alu[g]),
      .need_br     (op_br[g]),
      .rf_val      (op_rf[g]),
      .ex_wen      (ex_wen),
      .ex_dst      (ex_dst),
      .ex_load     (ex_load),
      .ex_result   (ex_result),
      .mem_wen     (mem_wen),
      .mem_dst     (mem_dst),
      .mem_load    (mem_load),
      .mem_result  (mem_result),
      .br_ex_block (any_br_ex),
      .val         (op_val[g]),
      .tag         (op_tag[g]),
      .m2d         (op_m2d[g]),
      .alu_stall   (op_astall[g]),
      .br_ex_haz   (op_brex[g]),
      .br_mem_stall(op_brmem[g])
    );
  end

  always_comb begin
    rs_val       = op_val[0];
    rt_val       = op_val[1];
    rs_src       = op_tag[0];
    rt_src       = op_tag[1];
    rs_m2d       = op_m2d[0];
    rt_m2d       = op_m2d[1];
    branch_stall = any_br_ex;
    stall        = any_br_ex || (|op_astall) || (|op_brmem);
  end

  always_comb begin
    AST_BRSTALL_HOLDS: assert (!branch_stall || stall); // R7
    AST_ZERO_DST_CLEAN: assert (!(ex_dst == '0 && mem_dst == '0) ||
      (!stall && rs_src == SRC_REGFILE && rt_src == SRC_REGFILE && !rs_m2d && !rt_m2d)); // R2
    AST_PASS_THROUGH: assert (stall || rs_src != SRC_REGFILE || rs_m2d || rs_val == rf_rs_val); // R11
    AST_M2D_NO_STALL_EX: assert (!(rs_m2d || rt_m2d) || !branch_stall); // R9
  end
endmodule

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        fwd_en;
  logic [4:0]  dec_rs_idx, dec_rt_idx, ex_dst, mem_dst;
  logic        dec_rs_alu, dec_rt_alu, dec_rs_br, dec_rt_br;
  logic [31:0] rf_rs_val, rf_rt_val, ex_result, mem_result;
  logic        ex_wen, ex_load, mem_wen, mem_load;
  logic [31:0] rs_val, rt_val;
  logic [1:0]  rs_src, rt_src;
  logic        rs_m2d, rt_m2d, stall, branch_stall;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  fwd_hazard_unit uut (.*);

  // expected packing: {stall, branch_stall, rs_m2d, rt_m2d, rs_src, rt_src, rs_val, rt_val}
  function automatic logic [71:0] model();
    logic [4:0]  idx [2];
    logic        na [2], nb [2];
    logic [31:0] rf [2], v [2];
    logic [1:0]  t [2];
    logic        f [2];
    logic        exm [2], mm [2];
    logic        bex, st;
    idx[0] = dec_rs_idx; idx[1] = dec_rt_idx;
    na[0] = dec_rs_alu;  na[1] = dec_rt_alu;
    nb[0] = dec_rs_br;   nb[1] = dec_rt_br;
    rf[0] = rf_rs_val;   rf[1] = rf_rt_val;
    bex = 1'b0; st = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exm[i] = ex_wen && ex_dst != 5'd0 && ex_dst == idx[i];
      mm[i]  = mem_wen && mem_dst != 5'd0 && mem_dst == idx[i];
      if (nb[i] && exm[i]) bex = 1'b1;
    end
    for (int i = 0; i < 2; i++) begin
      v[i] = rf[i]; t[i] = 2'd0; f[i] = 1'b0;
      if (na[i]) begin
        if (!fwd_en) begin
          if (exm[i] || mm[i]) st = 1'b1;
        end else begin
          if (exm[i] && ex_load) st = 1'b1;
          if (exm[i] && !ex_load) begin v[i] = ex_result; t[i] = 2'd2; end
          else if (mm[i]) begin v[i] = mem_result; t[i] = 2'd1; end
        end
      end
      if (nb[i] && mm[i]) begin
        if (!fwd_en || mem_load) st = 1'b1;
        else if (!bex) begin
          f[i] = 1'b1;
          if (t[i] != 2'd2) v[i] = mem_result;
        end
      end
    end
    if (bex) st = 1'b1;
    return {st, bex, f[0], f[1], t[0], t[1], v[0], v[1]};
  endfunction

  function automatic logic [71:0] actual();
    return {stall, branch_stall, rs_m2d, rt_m2d, rs_src, rt_src, rs_val, rt_val};
  endfunction

  task automatic check(input string req);
    logic [71:0] exp_v, act_v;
    @(negedge clk);
    exp_v = model();
    act_v = actual();
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic check_bit(input string req, input logic a, input logic e);
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, a, e);
    end
  endtask

  task automatic idle();
    fwd_en = 1'b1;
    dec_rs_idx = 5'd0; dec_rt_idx = 5'd0;
    dec_rs_alu = 1'b0; dec_rt_alu = 1'b0; dec_rs_br = 1'b0; dec_rt_br = 1'b0;
    rf_rs_val = 32'h1111_0001; rf_rt_val = 32'h2222_0002;
    ex_wen = 1'b0; ex_dst = 5'd0; ex_load = 1'b0; ex_result = 32'hE0E0_E0E0;
    mem_wen = 1'b0; mem_dst = 5'd0; mem_load = 1'b0; mem_result = 32'hA0A0_A0A0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R11: reset/idle state passes values through
    check("R11");
    check_bit("R11 stall", stall, 1'b0);
    check_bit("R11 rs_val", rs_val == 32'h1111_0001, 1'b1);

    // R3: memory-stage forward to ALU operand
    @(posedge clk); idle();
    dec_rs_idx = 5'd4; dec_rs_alu = 1'b1; mem_wen = 1'b1; mem_dst = 5'd4;
    check("R3");
    check_bit("R3 tag", rs_src == 2'b01 && rs_val == 32'hA0A0_A0A0, 1'b1);

    // R4: execute wins over memory
    @(posedge clk); ex_wen = 1'b1; ex_dst = 5'd4;
    check("R4");
    check_bit("R4 tag", rs_src == 2'b10 && rs_val == 32'hE0E0_E0E0, 1'b1);

    // R5: execute-stage load stalls, memory still forwards
    @(posedge clk); ex_load = 1'b1;
    check("R5");
    check_bit("R5 stall", stall && rs_src == 2'b01, 1'b1);

    // R2: register 0 destination ignored
    @(posedge clk); idle();
    dec_rs_alu = 1'b1; dec_rt_br = 1'b1; ex_wen = 1'b1; mem_wen = 1'b1;
    check("R2");
    check_bit("R2 stall", stall, 1'b0);

    // R1: operand not needed -> no effect
    @(posedge clk); idle();
    dec_rt_idx = 5'd7; ex_wen = 1'b1; ex_dst = 5'd7;
    check("R1");
    check_bit("R1 rt pass", rt_val == 32'h2222_0002 && !stall, 1'b1);

    // R6: stall-only mode
    @(posedge clk); idle(); fwd_en = 1'b0;
    dec_rt_idx = 5'd9; dec_rt_alu = 1'b1; mem_wen = 1'b1; mem_dst = 5'd9;
    check("R6");
    check_bit("R6 stall notag", stall && rt_src == 2'b00, 1'b1);

    // R7: branch operand on execute producer
    @(posedge clk); idle();
    dec_rs_idx = 5'd3; dec_rs_br = 1'b1; ex_wen = 1'b1; ex_dst = 5'd3;
    dec_rt_idx = 5'd5; dec_rt_br = 1'b1; mem_wen = 1'b1; mem_dst = 5'd5;
    check("R7");
    check_bit("R7 bstall nofwd", stall && branch_stall && !rt_m2d, 1'b1);

    // R8: branch operand on memory-stage load
    @(posedge clk); idle();
    dec_rt_idx = 5'd6; dec_rt_br = 1'b1; mem_wen = 1'b1; mem_dst = 5'd6; mem_load = 1'b1;
    check("R8");
    check_bit("R8 stall only", stall && !branch_stall && !rt_m2d, 1'b1);
    @(posedge clk); mem_load = 1'b0; fwd_en = 1'b0;
    check("R8 stall-only mode");

    // R9: memory-to-decode forward
    @(posedge clk); fwd_en = 1'b1;
    check("R9");
    check_bit("R9 fwd", rt_m2d && !stall && rt_val == 32'hA0A0_A0A0, 1'b1);

    // R10: link register 31
    @(posedge clk); idle();
    dec_rs_idx = 5'd31; dec_rs_alu = 1'b1; ex_wen = 1'b1; ex_dst = 5'd31;
    ex_result = 32'h0040_0108;
    check("R10");
    check_bit("R10 link", rs_val == 32'h0040_0108 && rs_src == 2'b10, 1'b1);

    // random mix over a clustered index set
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] pick [5];
      pick[0] = 5'd0; pick[1] = 5'd1; pick[2] = 5'd2; pick[3] = 5'd31; pick[4] = 5'd17;
      @(posedge clk);
      fwd_en     = $urandom_range(0, 3) != 0;
      dec_rs_idx = pick[$urandom_range(0, 4)];
      dec_rt_idx = pick[$urandom_range(0, 4)];
      dec_rs_alu = $urandom_range(0, 1); dec_rt_alu = $urandom_range(0, 1);
      dec_rs_br  = $urandom_range(0, 2) == 0; dec_rt_br = $urandom_range(0, 2) == 0;
      rf_rs_val  = $urandom; rf_rt_val = $urandom;
      ex_wen     = $urandom_range(0, 3) != 0; ex_dst = pick[$urandom_range(0, 4)];
      ex_load    = $urandom_range(0, 3) == 0; ex_result = $urandom;
      mem_wen    = $urandom_range(0, 3) != 0; mem_dst = pick[$urandom_range(0, 4)];
      mem_load   = $urandom_range(0, 3) == 0; mem_result = $urandom;
      check("R1 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule